// File: doc/BRIEF.md
# Quadrature Shaft Position Tracker

This block follows the absolute position of a rotating shaft from its two quadrature channels. Both channels are sampled by the one system clock. Each channel passes through two registers in series. The first stage catches the raw level. The second stage holds that value for one more clock, so the block always has a new sample and a previous sample of each channel.

A channel whose two samples differ raises a one-clock edge pulse, and that pulse enables the position counter. At the same rising edge, a direction decoder reads the four sample bits as one index and chooses the way to count:
- one way of turning counts up;
- the other way counts down;
- a clock in which both channels change at once is refused as illegal. The count holds and a sticky fault flag is set.

The position is a two's complement count that wraps around at both ends. A direction flag shows which way the last counted step went.

Top module: `qenc_tracker`

## Requirements
- R1: While `rst` is high at a rising edge, the position becomes 0, `cw_dir_o` becomes 0, `fault_o` becomes 0 and all sample registers become 0. Reset is synchronous and active high.
- R2: A change on an input channel moves the position only after exactly two rising edges. After the first rising edge that follows the change, the position has not yet moved.
- R3: Write the channels as the pair AB = {chan_a_i, chan_b_i}. A step along 00 -> 01 -> 11 -> 10 -> 00 is clockwise. The decoder index {A new, A previous, B new, B previous}, with A new as the most significant bit, then takes one of the values 2, 4, 11 or 13. On such a step the position rises by 1 and `cw_dir_o` becomes 1.
- R4: A step along the reverse order (indices 1, 7, 8 or 14) lowers the position by 1 and sets `cw_dir_o` to 0.
- R5: While neither channel changes (indices 0, 3, 12 and 15), the position and `cw_dir_o` hold their values.
- R6: When both channels change in the same clock (indices 5, 6, 9 and 10), the position and `cw_dir_o` hold. `fault_o` becomes 1 and stays 1 until reset, including through later legal steps.
- R7: The position wraps as a `POS_W`-bit two's complement value. Counting up from the largest positive value gives the most negative value, and counting down from it gives the largest positive value again.
- R8: A reversal of direction is counted on the edge where it is seen. Each step is judged only against the step immediately before it.
- R9: Asserting `rst` while the block is running clears a non-zero position and a set fault flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| chan_a_i | input | 1 | Quadrature channel A, asynchronous |
| chan_b_i | input | 1 | Quadrature channel B, asynchronous |
| position_o | output | POS_W | Signed shaft position count |
| cw_dir_o | output | 1 | Direction of the last counted step, 1 = clockwise |
| fault_o | output | 1 | Sticky flag for a both-channels-change event |

## Verification
The bench builds the tracker with `POS_W` = 4. With that width, a walk of a few dozen steps crosses the wrap point in both directions.

The bench sweeps all sixteen pairs of previous and new channel states, each starting from a fresh reset. Every pair reached by a one-channel change gives a count up, a count down or a hold. The remaining pairs, where both channels move, give the illegal case. Each expected position comes from the Gray position difference taken modulo four.

A mixed walk with reversals then checks the two-edge latency and the sticky fault flag against the same arithmetic model.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        MV_NONE = 2'd0,
        MV_CW   = 2'd1,
        MV_CCW  = 2'd2,
        MV_BAD  = 2'd3
    } move_e;

    typedef struct packed {
        logic cur;   // newest registered sample
        logic prv;   // sample one clock older
    } chan_smp_s;

    // Index order is {A new, A previous, B new, B previous}.
    function automatic move_e decode_move(input logic [3:0] idx);
        move_e m;
        case (idx)
            4'd2, 4'd4, 4'd11, 4'd13: m = MV_CW;
            4'd1, 4'd7, 4'd8, 4'd14:  m = MV_CCW;
            4'd5, 4'd6, 4'd9, 4'd10:  m = MV_BAD;
            default:                  m = MV_NONE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/qenc_channel.sv
module qenc_channel
    import qenc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      raw_i,
    output chan_smp_s smp_o,
    output logic      edge_o
);
    logic sync_q;
    logic xfer_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            xfer_q <= 1'b0;
        end else begin
            sync_q <= raw_i;
            xfer_q <= sync_q;
        end
    end

    assign smp_o  = '{cur: sync_q, prv: xfer_q};
    assign edge_o = sync_q ^ xfer_q;

    // R2: the transfer stage always repeats the synchronizer one clock later.
    a_r2_xfer_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (xfer_q == $past(sync_q)));

endmodule

// File: rtl/qenc_dir_decoder.sv
module qenc_dir_decoder
    import qenc_pkg::*;
(
    input  chan_smp_s smp_a_i,
    input  chan_smp_s smp_b_i,
    output move_e     move_o
);
    logic [3:0] idx;

    assign idx    = {smp_a_i.cur, smp_a_i.prv, smp_b_i.cur, smp_b_i.prv};
    assign move_o = decode_move(idx);

endmodule

// File: rtl/qenc_pos_counter.sv
module qenc_pos_counter
    import qenc_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step_en_i,
    input  move_e                   move_i,
    output logic signed [POS_W-1:0] pos_o,
    output logic                    cw_o,
    output logic                    fault_o
);
    localparam logic [POS_W-1:0] ONE = {{(POS_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_o   <= '0;
            cw_o    <= 1'b0;
            fault_o <= 1'b0;
        end else if (step_en_i) begin
            case (move_i)
                MV_CW: begin
                    pos_o <= pos_o + ONE;
                    cw_o  <= 1'b1;
                end
                MV_CCW: begin
                    pos_o <= pos_o - ONE;
                    cw_o  <= 1'b0;
                end
                MV_BAD:  fault_o <= 1'b1;
                default: ;
            endcase
        end
    end

    // R5: the edge pulses and the decoder agree on whether anything changed.
    a_r5_enable_matches_move: assert property (@(posedge clk) disable iff (rst)
        step_en_i == (move_i != MV_NONE));

    // R5: with no edge pulse the count and direction stay put.
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !step_en_i |=> ($stable(pos_o) && $stable(cw_o)));

    // R3, R7: a clockwise step adds one, modulo 2^POS_W.
    a_r3_count_up: assert property (@(posedge clk) disable iff (rst)
        (step_en_i && move_i == MV_CW) |=> (pos_o == $past(pos_o) + ONE) && cw_o);

    // R4, R7: a counter-clockwise step subtracts one, modulo 2^POS_W.
    a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
        (step_en_i && move_i == MV_CCW) |=> (pos_o == $past(pos_o) - ONE) && !cw_o);

    // R6: an illegal step holds the count and raises the fault.
    a_r6_bad_holds: assert property (@(posedge clk) disable iff (rst)
        (step_en_i && move_i == MV_BAD) |=> $stable(pos_o) && fault_o);

    // R6: the fault flag is sticky.
    a_r6_fault_sticky: assert property (@(posedge clk) disable iff (rst)
        fault_o |=> fault_o);

    // R1: reset clears the count.
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (pos_o == '0) && !fault_o && !cw_o);

endmodule

// File: rtl/qenc_tracker.sv
module qenc_tracker
    import qenc_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    chan_a_i,
    input  logic                    chan_b_i,
    output logic signed [POS_W-1:0] position_o,
    output logic                    cw_dir_o,
    output logic                    fault_o
);
    logic [NUM_CH-1:0] raw;
    logic [NUM_CH-1:0] edge_pulse;
    chan_smp_s         smp [NUM_CH];
    move_e             move;
    logic              step_en;

    assign raw = {chan_b_i, chan_a_i};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        qenc_channel u_chan (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw[c]),
            .smp_o  (smp[c]),
            .edge_o (edge_pulse[c])
        );
    end

    qenc_dir_decoder u_dec (
        .smp_a_i (smp[0]),
        .smp_b_i (smp[1]),
        .move_o  (move)
    );

    assign step_en = |edge_pulse;

    qenc_pos_counter #(.POS_W(POS_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .step_en_i (step_en),
        .move_i    (move),
        .pos_o     (position_o),
        .cw_o      (cw_dir_o),
        .fault_o   (fault_o)
    );

    // R6: a both-channels-change never moves the count.
    a_r6_double_change_no_count: assert property (@(posedge clk) disable iff (rst)
        (&edge_pulse) |=> $stable(position_o));

endmodule

// File: tb/qenc_tracker_bench.sv
`timescale 1ns/1ps
module qenc_tracker_bench;

    localparam int POS_W = 4;
    localparam int MASK  = (1 << POS_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_in = 1'b0;
    logic b_in = 1'b0;
    logic signed [POS_W-1:0] pos;
    logic cw_dir;
    logic fault;

    int checks   = 0;
    int failures = 0;

    int m_pos   = 0;
    int m_dir   = 0;
    int m_fault = 0;
    int m_ab    = 0;

    always #2.5 clk = ~clk;

    qenc_tracker #(.POS_W(POS_W)) u_qenc_tracker (
        .clk        (clk),
        .rst        (rst),
        .chan_a_i   (a_in),
        .chan_b_i   (b_in),
        .position_o (pos),
        .cw_dir_o   (cw_dir),
        .fault_o    (fault)
    );

    // Gray position of an AB pair: 00 -> 0, 01 -> 1, 11 -> 2, 10 -> 3
    function automatic int gray_pos(input int ab);
        case (ab & 3)
            0: return 0;
            1: return 1;
            3: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic int pos_to_ab(input int p);
        case (p & 3)
            0: return 0;
            1: return 1;
            2: return 3;
            default: return 2;
        endcase
    endfunction

    task automatic check_eq(input string req, input string what,
                            input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check_eq(req, "position", int'($unsigned(pos)), m_pos & MASK);
        check_eq(req, "cw_dir", int'(cw_dir), m_dir);
        check_eq(req, "fault", int'(fault), m_fault);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst  = 1'b1;
        a_in = 1'b0;
        b_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_pos = 0; m_dir = 0; m_fault = 0; m_ab = 0;
    endtask

    // Drive a new AB pair and check latency, result and hold afterwards.
    task automatic apply_ab(input int ab_new, input string req);
        int d;
        int old_pos;
        old_pos = m_pos;
        d = (gray_pos(ab_new) - gray_pos(m_ab)) & 3;
        @(negedge clk);
        a_in = ab_new[1];
        b_in = ab_new[0];
        @(negedge clk);
        // R2: one edge after the change, nothing has moved yet
        check_eq("R2", "position after one edge", int'($unsigned(pos)), old_pos & MASK);
        if (d == 1) begin
            m_pos = m_pos + 1; m_dir = 1;
        end else if (d == 3) begin
            m_pos = m_pos - 1; m_dir = 0;
        end else if (d == 2) begin
            m_fault = 1;
        end
        m_ab = ab_new;
        @(negedge clk);
        check_all(req);
        repeat (2) @(negedge clk);
        check_all("R5");
    endtask

    task automatic step_dir(input int up, input string req);
        int p;
        p = gray_pos(m_ab) + (up != 0 ? 1 : 3);
        apply_ab(pos_to_ab(p), req);
    endtask

    initial begin : main
        logic [7:0] lfsr;
        string req;
        int d;
        lfsr = 8'hA5;

        // R1: reset state
        do_reset();
        repeat (2) @(negedge clk);
        check_all("R1");

        // Exhaustive sweep over every previous/new channel pair (R3 R4 R5 R6 R8)
        for (int old_p = 0; old_p < 4; old_p++) begin
            for (int new_ab = 0; new_ab < 4; new_ab++) begin
                do_reset();
                for (int s = 0; s < old_p; s++) step_dir(1, "R3");
                d = (gray_pos(new_ab) - old_p) & 3;
                case (d)
                    1: req = "R3";
                    3: req = "R8";
                    2: req = "R6";
                    default: req = "R5";
                endcase
                apply_ab(new_ab, req);
            end
        end

        // R7: wrap upward past the largest positive value, then downward
        do_reset();
        for (int s = 0; s < 20; s++) step_dir(1, "R7");
        for (int s = 0; s < 40; s++) step_dir(0, "R7");

        // R4: counter-clockwise steps from zero
        do_reset();
        for (int s = 0; s < 5; s++) step_dir(0, "R4");

        // R8: mixed walk with frequent reversals
        for (int s = 0; s < 80; s++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step_dir(int'(lfsr[0]), "R8");
        end

        // R6: double change sets fault, legal steps afterwards keep it set
        apply_ab(m_ab ^ 3, "R6");
        for (int s = 0; s < 3; s++) step_dir(1, "R6");

        // R9: reset while running clears position and fault
        step_dir(1, "R3");
        do_reset();
        repeat (2) @(negedge clk);
        check_all("R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : watchdog
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule